// File: doc/BRIEF.md
# E1 Multiframe Aligner (CRC-4 and CAS)

This block sits behind a basic-frame aligner on an E1 receive path. For each received frame it gets one strobe. With the strobe come a flag that says whether the frame carries the frame alignment signal, the first bit of timeslot 0, and the whole timeslot 16 octet. Once per submultiframe it also gets a pass/fail result from an external CRC-4 checker. From these inputs it finds two independent 16-frame structures: the CRC-4 multiframe and the channel-associated-signalling multiframe. For each one it reports a sync flag and the position of the most recent frame inside that multiframe.

CRC-4 alignment takes two steps. A first hit on the alignment word opens a 64-frame window. A second hit at the same phase inside that window declares sync. While in sync, the block counts codeword failures in blocks of 1000. A block with too many failures forces a new search. CAS alignment needs a zero nibble that follows a non-zero timeslot 16 octet. CAS sync is dropped after repeated misses. When the basic frame lock drops, everything restarts.

Top module: `e1_mf_aligner`

## Requirements
- R1: While CRC-4 is hunting, the bits taken from `ts0_bit1` of frames with `frm_has_fas`=0 are collected. When the last six of them, oldest first, read 0,0,1,0,1,1, the CRC-4 frame counter is set to 11 on that frame. `crc_mf_sync` stays 0 at this point.
- R2: `crc_mf_sync` becomes 1 on the frame where a second such word ends exactly 16 frames after the first one. On that frame `crc_mf_frame` reads 11.
- R3: If no second word at the matching phase arrives within 64 frames after the first, the search starts over. A word that arrives later counts only as a new first hit.
- R4: While in CRC-4 sync, `smf_done` pulses are counted in blocks of 1000. If 915 or more pulses in a block have `smf_crc_err`=1, `crc_mf_sync` falls in the cycle after the 1000th pulse.
- R5: A block of 1000 pulses with 914 or fewer errors leaves `crc_mf_sync` at 1. The count starts fresh with every block.
- R6: While CAS is hunting, a frame whose `ts16_octet[7:4]` is 0000 declares CAS sync only if the previous frame's `ts16_octet` was non-zero. The first frame after lock has no predecessor and never declares sync. On the sync frame `cas_mf_frame` reads 0.
- R7: While in CAS sync, frames where `cas_mf_frame` wraps to 0 must carry 0000 in `ts16_octet[7:4]`. One bad word followed by a good one keeps sync. Two bad words in a row drop `cas_mf_sync`.
- R8: When `frm_lock` is 0, both sync flags and both frame counters read 0 from the next cycle, and both searches restart.
- R9: Each frame strobe advances both frame counters by one, with a wrap from 15 to 0. The counters hold when there is no strobe.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_lock | input | 1 | Basic frame alignment held |
| frm_strobe | input | 1 | One-cycle pulse per received frame; the other frame inputs are valid with it |
| frm_has_fas | input | 1 | Frame carries the frame alignment signal |
| ts0_bit1 | input | 1 | First bit of timeslot 0 |
| ts16_octet | input | 8 | Timeslot 16 octet, bit 7 first |
| smf_done | input | 1 | One-cycle pulse per checked submultiframe |
| smf_crc_err | input | 1 | CRC-4 mismatch for that submultiframe |
| crc_mf_sync | output | 1 | CRC-4 multiframe sync |
| crc_mf_frame | output | 4 | CRC-4 multiframe position of last frame |
| cas_mf_sync | output | 1 | CAS multiframe sync |
| cas_mf_frame | output | 4 | CAS multiframe position of last frame |

## Verification
The hardest state to reach is a forced CRC-4 resync. It needs sync to be held for a full 1000-codeword block with a chosen error count. At eight frames per codeword that would mean thousands of frames. The stimulus gets there by pulsing `smf_done` back to back with no frame strobes, once with 914 errors and once with 915. Window expiry is reached by spoiling one word bit across four whole multiframes after a first hit. Random payload, E bits and signalling nibbles fill all other positions.

// File: rtl/e1_mfa_pkg.sv
package e1_mfa_pkg;
  localparam int unsigned MF_FRAMES    = 16;
  localparam int unsigned MF_CNT_W     = $clog2(MF_FRAMES);
  localparam logic [5:0]  CRC_MFAS     = 6'b001011;
  localparam int unsigned CRC_WORD_END = 11;

  typedef enum logic [1:0] {
    CRC_HUNT = 2'd0,
    CRC_WAIT = 2'd1,
    CRC_LOCK = 2'd2
  } crc_state_e;
endpackage

// File: rtl/crc4_err_monitor.sv
module crc4_err_monitor #(
  parameter int unsigned BLOCK_LEN = 1000,
  parameter int unsigned ERR_LIMIT = 915
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic smf_done,
  input  logic smf_err,
  output logic resync
);
  localparam int unsigned BLK_W = $clog2(BLOCK_LEN + 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCK_LEN - 1);
  localparam logic [BLK_W-1:0] ERR_TRIP = BLK_W'(ERR_LIMIT);

  logic [BLK_W-1:0] blk_cnt, blk_cnt_n;
  logic [BLK_W-1:0] err_cnt, err_cnt_n;
  logic [BLK_W-1:0] err_tot;
  logic             blk_end;

  always_comb begin
    err_tot   = err_cnt + BLK_W'(smf_err);
    blk_end   = (blk_cnt == BLK_LAST);
    blk_cnt_n = blk_cnt;
    err_cnt_n = err_cnt;
    resync    = 1'b0;
    if (!active) begin
      blk_cnt_n = '0;
      err_cnt_n = '0;
    end else if (smf_done) begin
      if (blk_end) begin
        resync    = (err_tot >= ERR_TRIP);
        blk_cnt_n = '0;
        err_cnt_n = '0;
      end else begin
        blk_cnt_n = blk_cnt + 1'b1;
        err_cnt_n = err_tot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt <= '0;
      err_cnt <= '0;
    end else begin
      blk_cnt <= blk_cnt_n;
      err_cnt <= err_cnt_n;
    end
  end

  AST_ERR_WITHIN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= blk_cnt); // R5
  AST_IDLE_WHEN_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (blk_cnt == '0) && (err_cnt == '0)); // R5
endmodule

// File: rtl/crc4_mf_align.sv
module crc4_mf_align
  import e1_mfa_pkg::*;
#(
  parameter int unsigned WINDOW_FRAMES = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock,
  input  logic                strobe,
  input  logic                fas_frame,
  input  logic                mf_bit,
  input  logic                resync,
  output logic                sync,
  output logic [MF_CNT_W-1:0] frame_cnt
);
  localparam int unsigned WIN_W = $clog2(WINDOW_FRAMES);
  localparam logic [WIN_W-1:0]    WIN_LAST = WIN_W'(WINDOW_FRAMES - 1);
  localparam logic [MF_CNT_W-1:0] CNT_LAST = MF_CNT_W'(MF_FRAMES - 1);
  localparam logic [MF_CNT_W-1:0] CNT_WORD = MF_CNT_W'(CRC_WORD_END);

  crc_state_e          state, state_n;
  logic [5:0]          shreg, shreg_n;
  logic [MF_CNT_W-1:0] cnt_n, cnt_inc;
  logic [WIN_W-1:0]    win, win_n;
  logic                shift_en, word_hit;

  always_comb begin
    shift_en = strobe && !fas_frame;
    word_hit = shift_en && ({shreg[4:0], mf_bit} == CRC_MFAS);
    cnt_inc  = (frame_cnt == CNT_LAST) ? '0 : frame_cnt + 1'b1;
    state_n  = state;
    shreg_n  = shreg;
    cnt_n    = frame_cnt;
    win_n    = win;
    if (!lock) begin
      state_n = CRC_HUNT;
      shreg_n = '1;
      cnt_n   = '0;
      win_n   = '0;
    end else begin
      if (shift_en) shreg_n = {shreg[4:0], mf_bit};
      if (strobe)   cnt_n   = cnt_inc;
      unique case (state)
        CRC_HUNT: begin
          if (word_hit) begin
            state_n = CRC_WAIT;
            cnt_n   = CNT_WORD;
            win_n   = '0;
          end
        end
        CRC_WAIT: begin
          if (strobe) begin
            if (word_hit && cnt_inc == CNT_WORD) begin
              state_n = CRC_LOCK;
            end else if (word_hit) begin
              cnt_n = CNT_WORD;
              win_n = '0;
            end else if (win == WIN_LAST) begin
              state_n = CRC_HUNT;
            end else begin
              win_n = win + 1'b1;
            end
          end
        end
        CRC_LOCK: begin
          if (resync) state_n = CRC_HUNT;
        end
        default: state_n = CRC_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CRC_HUNT;
      shreg     <= '1;
      frame_cnt <= '0;
      win       <= '0;
    end else begin
      state     <= state_n;
      shreg     <= shreg_n;
      frame_cnt <= cnt_n;
      win       <= win_n;
    end
  end

  assign sync = (state == CRC_LOCK);

  AST_SYNC_ON_WORD_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> frame_cnt == CNT_WORD); // R2
  AST_RESYNC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && resync) |=> !sync); // R4
  AST_CRC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && strobe && sync) |=>
      frame_cnt == (($past(frame_cnt) == CNT_LAST) ? '0 : $past(frame_cnt) + 1'b1)); // R9
endmodule

// File: rtl/cas_mf_align.sv
module cas_mf_align
  import e1_mfa_pkg::*;
#(
  parameter int unsigned MISS_LIMIT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock,
  input  logic                strobe,
  input  logic [7:0]          ts16,
  output logic                sync,
  output logic [MF_CNT_W-1:0] frame_cnt
);
  localparam int unsigned MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [MISS_W-1:0]   MISS_LAST = MISS_W'(MISS_LIMIT - 1);
  localparam logic [MF_CNT_W-1:0] CNT_LAST  = MF_CNT_W'(MF_FRAMES - 1);

  logic                sync_n, prev_nz, prev_nz_n;
  logic [MF_CNT_W-1:0] cnt_n, cnt_inc;
  logic [MISS_W-1:0]   miss, miss_n;
  logic                word_ok;

  always_comb begin
    word_ok   = (ts16[7:4] == 4'h0);
    cnt_inc   = (frame_cnt == CNT_LAST) ? '0 : frame_cnt + 1'b1;
    sync_n    = sync;
    prev_nz_n = prev_nz;
    cnt_n     = frame_cnt;
    miss_n    = miss;
    if (!lock) begin
      sync_n    = 1'b0;
      prev_nz_n = 1'b0;
      cnt_n     = '0;
      miss_n    = '0;
    end else if (strobe) begin
      prev_nz_n = |ts16;
      cnt_n     = cnt_inc;
      if (!sync) begin
        if (word_ok && prev_nz) begin
          sync_n = 1'b1;
          cnt_n  = '0;
          miss_n = '0;
        end
      end else if (cnt_inc == '0) begin
        if (word_ok) begin
          miss_n = '0;
        end else if (miss == MISS_LAST) begin
          sync_n = 1'b0;
          miss_n = '0;
        end else begin
          miss_n = miss + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync      <= 1'b0;
      prev_nz   <= 1'b0;
      frame_cnt <= '0;
      miss      <= '0;
    end else begin
      sync      <= sync_n;
      prev_nz   <= prev_nz_n;
      frame_cnt <= cnt_n;
      miss      <= miss_n;
    end
  end

  AST_CAS_SYNC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> frame_cnt == '0); // R6
  AST_CAS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !strobe) |=> $stable(frame_cnt)); // R9
  AST_CAS_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    miss < MISS_W'(MISS_LIMIT)); // R7
endmodule

// File: rtl/e1_mf_aligner.sv
module e1_mf_aligner
  import e1_mfa_pkg::*;
#(
  parameter int unsigned WINDOW_FRAMES  = 64,
  parameter int unsigned BLOCK_LEN      = 1000,
  parameter int unsigned ERR_LIMIT      = 915,
  parameter int unsigned CAS_MISS_LIMIT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frm_lock,
  input  logic                frm_strobe,
  input  logic                frm_has_fas,
  input  logic                ts0_bit1,
  input  logic [7:0]          ts16_octet,
  input  logic                smf_done,
  input  logic                smf_crc_err,
  output logic                crc_mf_sync,
  output logic [MF_CNT_W-1:0] crc_mf_frame,
  output logic                cas_mf_sync,
  output logic [MF_CNT_W-1:0] cas_mf_frame
);
  logic [1:0] rst_pipe;
  logic       rst_n_int;
  logic       crc_resync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  crc4_mf_align #(.WINDOW_FRAMES(WINDOW_FRAMES)) u_crc_align (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .lock      (frm_lock),
    .strobe    (frm_strobe),
    .fas_frame (frm_has_fas),
    .mf_bit    (ts0_bit1),
    .resync    (crc_resync),
    .sync      (crc_mf_sync),
    .frame_cnt (crc_mf_frame)
  );

  crc4_err_monitor #(.BLOCK_LEN(BLOCK_LEN), .ERR_LIMIT(ERR_LIMIT)) u_err_mon (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .active   (crc_mf_sync),
    .smf_done (smf_done),
    .smf_err  (smf_crc_err),
    .resync   (crc_resync)
  );

  cas_mf_align #(.MISS_LIMIT(CAS_MISS_LIMIT)) u_cas_align (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .lock      (frm_lock),
    .strobe    (frm_strobe),
    .ts16      (ts16_octet),
    .sync      (cas_mf_sync),
    .frame_cnt (cas_mf_frame)
  );

  AST_LOCK_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_int)
    !frm_lock |=> !crc_mf_sync && !cas_mf_sync && crc_mf_frame == '0 && cas_mf_frame == '0); // R8
endmodule

// File: tb/e1_mf_aligner_test.sv
`timescale 1ns/1ps
module e1_mf_aligner_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frm_lock, frm_strobe, frm_has_fas, ts0_bit1;
  logic [7:0] ts16_octet;
  logic       smf_done, smf_crc_err;
  logic       crc_mf_sync, cas_mf_sync;
  logic [3:0] crc_mf_frame, cas_mf_frame;

  int n_chk  = 0;
  int n_fail = 0;
  int g_crc  = 0;
  int g_cas  = 0;
  bit crc_bad = 0;
  bit cas_bad = 0;
  bit track   = 0;

  always #2 clk = ~clk;

  e1_mf_aligner uut (
    .clk(clk), .rst_n(rst_n), .frm_lock(frm_lock), .frm_strobe(frm_strobe),
    .frm_has_fas(frm_has_fas), .ts0_bit1(ts0_bit1), .ts16_octet(ts16_octet),
    .smf_done(smf_done), .smf_crc_err(smf_crc_err),
    .crc_mf_sync(crc_mf_sync), .crc_mf_frame(crc_mf_frame),
    .cas_mf_sync(cas_mf_sync), .cas_mf_frame(cas_mf_frame)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bit carried in ts0 bit 1 of CRC-4 frame idx (word 001011 in odd frames 1..11)
  function automatic logic crc_bit(input int idx, input bit bad);
    logic [5:0] w;
    logic b;
    w = 6'b001011;
    if ((idx % 2) == 1 && idx <= 11) begin
      b = w[5 - (idx >> 1)];
      if (bad && idx == 5) b = ~b;
    end else begin
      b = logic'($urandom % 2);
    end
    return b;
  endfunction

  // Timeslot 16 content for CAS frame idx: word 0000 in upper nibble of frame 0
  function automatic logic [7:0] cas_octet(input int idx, input bit bad);
    logic [3:0] hi;
    if (idx == 0) hi = bad ? 4'(1 + ($urandom % 15)) : 4'h0;
    else          hi = 4'(1 + ($urandom % 15));
    return {hi, 4'($urandom % 16)};
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      frm_strobe  = 1'b1;
      frm_has_fas = ((g_crc % 2) == 0);
      ts0_bit1    = crc_bit(g_crc, crc_bad);
      ts16_octet  = cas_octet(g_cas, cas_bad);
      @(negedge clk);
      frm_strobe = 1'b0;
      if (track) begin
        check("R9 crc counter", int'(crc_mf_frame), g_crc);
        check("R9 cas counter", int'(cas_mf_frame), g_cas);
      end
      g_crc = (g_crc + 1) % 16;
      g_cas = (g_cas + 1) % 16;
      if (($urandom % 3) == 0) begin
        @(negedge clk);
        if (track) begin
          check("R9 crc hold", int'(crc_mf_frame), (g_crc + 15) % 16);
          check("R9 cas hold", int'(cas_mf_frame), (g_cas + 15) % 16);
        end
      end
    end
  endtask

  task automatic step_to_cas0();
    while (g_cas != 0) step(1);
  endtask

  task automatic step_to_crc0();
    while (g_crc != 0) step(1);
  endtask

  task automatic codewords(input int total, input int errs);
    for (int i = 0; i < total; i++) begin
      smf_done    = 1'b1;
      smf_crc_err = (i >= total - errs);
      @(negedge clk);
    end
    smf_done    = 1'b0;
    smf_crc_err = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; frm_lock = 1'b0; frm_strobe = 1'b0; frm_has_fas = 1'b0;
    ts0_bit1 = 1'b0; ts16_octet = 8'h00; smf_done = 1'b0; smf_crc_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check("R10 crc sync", int'(crc_mf_sync), 0);
    check("R10 crc frame", int'(crc_mf_frame), 0);
    check("R10 cas sync", int'(cas_mf_sync), 0);
    check("R10 cas frame", int'(cas_mf_frame), 0);

    frm_lock = 1'b1;
    @(negedge clk);
    g_crc = 0; g_cas = 5;
    step(12);
    check("R1 first word no sync", int'(crc_mf_sync), 0);
    check("R1 counter set to 11", int'(crc_mf_frame), 11);
    check("R6 cas sync after nonzero", int'(cas_mf_sync), 1);
    check("R6 cas frame zero", int'(cas_mf_frame), 0);
    step(16);
    check("R2 second word sync", int'(crc_mf_sync), 1);
    check("R2 frame 11", int'(crc_mf_frame), 11);

    track = 1;
    step(40);
    track = 0;

    // R7 single miss keeps, double miss drops
    step_to_cas0();
    cas_bad = 1; step(1); cas_bad = 0;
    check("R7 one miss keeps", int'(cas_mf_sync), 1);
    step(16);
    check("R7 good word after miss", int'(cas_mf_sync), 1);
    step_to_cas0();
    cas_bad = 1; step(1); cas_bad = 0;
    check("R7 first of two misses", int'(cas_mf_sync), 1);
    step_to_cas0();
    cas_bad = 1; step(1); cas_bad = 0;
    check("R7 two misses drop", int'(cas_mf_sync), 0);
    check("R7 crc unaffected", int'(crc_mf_sync), 1);
    step_to_cas0(); step(1);
    check("R6 rehunt sync", int'(cas_mf_sync), 1);
    check("R6 rehunt frame", int'(cas_mf_frame), 0);

    // R5 then R4 error blocks
    codewords(1000, 914);
    check("R5 914 errors keep sync", int'(crc_mf_sync), 1);
    codewords(500, 500);
    check("R5 block restart keeps", int'(crc_mf_sync), 1);
    codewords(500, 0);
    check("R5 500 of 1000 keeps", int'(crc_mf_sync), 1);
    codewords(1000, 915);
    check("R4 915 errors drop sync", int'(crc_mf_sync), 0);

    // R3 window expiry
    step_to_crc0();
    step(16);
    check("R3 first hit only", int'(crc_mf_sync), 0);
    crc_bad = 1; step(64); crc_bad = 0;
    step(12);
    check("R3 late word no sync", int'(crc_mf_sync), 0);
    check("R3 late word sets counter", int'(crc_mf_frame), 11);
    step(16);
    check("R3 sync after new pair", int'(crc_mf_sync), 1);

    // R8 lock loss
    frm_lock = 1'b0;
    @(negedge clk);
    check("R8 crc sync cleared", int'(crc_mf_sync), 0);
    check("R8 cas sync cleared", int'(cas_mf_sync), 0);
    check("R8 crc frame cleared", int'(crc_mf_frame), 0);
    check("R8 cas frame cleared", int'(cas_mf_frame), 0);
    frm_lock = 1'b1;
    @(negedge clk);
    g_cas = 0;
    step(1);
    check("R6 no predecessor no sync", int'(cas_mf_sync), 0);
    step_to_cas0(); step(1);
    check("R6 sync after relock", int'(cas_mf_sync), 1);
    step_to_crc0(); step(12); step(16);
    check("R8 crc resync after relock", int'(crc_mf_sync), 1);
    check("R2 relock frame 11", int'(crc_mf_frame), 11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule